// File: doc/BRIEF.md
# Accumulator ALU with Flag Write Enables

This block is the byte-wide arithmetic and logic unit of an accumulator-based microcontroller core. Each cycle it takes an operation code, the accumulator, a second operand and the current carry (C), overflow (OV) and auxiliary-carry (AC) flags. It returns a main result byte for the accumulator and a secondary result byte for the operand location. It also returns the three flags, each with its own write enable. The core's register file commits only the flags whose enables are high.

Every operation has a fixed flag-effect profile. Arithmetic updates all three flags. Multiply and divide force C low and report OV. Decimal adjust and rotate-through-carry touch only C. The carry operations write only C. Logic, clear, complement, plain rotate, nibble swap and nibble exchange leave the flags alone. The block is purely combinational, so the results are valid in the same cycle as the inputs. Fetching operands and decoding direct addresses are left to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: Opcodes 0 (add) and 1 (add with carry-in from `cy_i`) give res_o = low byte of the sum. C is the carry out of bit 7, AC is the carry out of bit 3, and OV is the carry into bit 7 XOR the carry out of bit 7. All three write enables are 1.
- R2: Opcode 2 (subtract with borrow) gives res_o = acc - opnd - cy_i (mod 256). C is the borrow out of bit 7, AC is the borrow out of bit 3, and OV is set when the operands differ in sign and the result's sign differs from the accumulator's. All three write enables are 1.
- R3: Opcode 3 (decimal adjust) first adds 0x06 when acc[3:0] > 9 or AC is set. It then adds 0x60 when the intermediate high nibble is above 9 or C is set. C becomes 1 on any carry out of bit 7 and is never cleared. Only the C write enable is 1.
- R4: Opcode 4 (multiply) gives res_o = low byte and aux_o = high byte of acc*opnd, C = 0, and OV = 1 when the product exceeds 255. Only C and OV are enabled.
- R5: Opcode 5 (divide) gives res_o = quotient, aux_o = remainder, C = 0 and OV = 0. When opnd is zero it gives res_o = aux_o = 0x00 and OV = 1. Only C and OV are enabled.
- R6: Opcodes 6/7/8 (AND/OR/XOR of acc with opnd), 9 (clear acc to 0x00) and 10 (complement acc) write no flags.
- R7: Opcode 11 rotates acc left by one over 8 bits and opcode 13 rotates it right by one over 8 bits. Neither writes a flag.
- R8: Opcode 12 rotates left over the 9 bits {C,acc}, with C taking acc[7] and bit 0 taking the old C. Opcode 14 rotates right over 9 bits, with C taking acc[0] and bit 7 taking the old C. Only C is enabled.
- R9: Opcode 15 swaps the two nibbles of acc and writes no flag.
- R10: Opcode 16 sets C to 1, 17 clears C to 0, and 18 inverts C. res_o equals acc, and only C is enabled.
- R11: Opcode 19 exchanges the low nibbles: res_o = {acc[7:4], opnd[3:0]} and aux_o = {opnd[7:4], acc[3:0]}. No flag is written.
- R12: Any flag whose write enable is 0 is driven equal to its incoming value. aux_o equals opnd for every opcode except 4, 5 and 19. Opcodes 20..31 give res_o = acc with no enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| cy_i | input | 1 | Current carry flag |
| ov_i | input | 1 | Current overflow flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| res_o | output | 8 | Result for the accumulator |
| aux_o | output | 8 | Result for the operand location |
| cy_o | output | 1 | New carry flag |
| ov_o | output | 1 | New overflow flag |
| ac_o | output | 1 | New auxiliary-carry flag |
| cy_we_o | output | 1 | Carry write enable |
| ov_we_o | output | 1 | Overflow write enable |
| ac_we_o | output | 1 | Auxiliary-carry write enable |

## Verification
Addition is checked with a sweep of operand pairs against a signed-overflow rule derived from operand signs. This separates the carry-into-bit-7 term from the carry out. Subtraction uses operands whose low nibbles borrow while the high nibbles do not, and a sign-crossing case, so that AC, C and OV can each be wrong on its own. Decimal adjust is driven with a value needing both corrections, one needing only the low correction through AC, and one where an incoming C forces the high correction without a new carry. The incoming flags are set to patterns that differ from any flag value the operation could produce. This shows whether a flag with its enable low passes its input through unchanged.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         cy_i,
  input  logic         ov_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] aux_o,
  output logic         cy_o,
  output logic         ov_o,
  output logic         ac_o,
  output logic         cy_we_o,
  output logic         ov_we_o,
  output logic         ac_we_o
);
  localparam int H = W / 2;

  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADDC = 5'd1;
  localparam logic [4:0] OP_SUBB = 5'd2;
  localparam logic [4:0] OP_DA   = 5'd3;
  localparam logic [4:0] OP_MUL  = 5'd4;
  localparam logic [4:0] OP_DIV  = 5'd5;
  localparam logic [4:0] OP_AND  = 5'd6;
  localparam logic [4:0] OP_OR   = 5'd7;
  localparam logic [4:0] OP_XOR  = 5'd8;
  localparam logic [4:0] OP_CLRA = 5'd9;
  localparam logic [4:0] OP_CPLA = 5'd10;
  localparam logic [4:0] OP_RL   = 5'd11;
  localparam logic [4:0] OP_RLC  = 5'd12;
  localparam logic [4:0] OP_RR   = 5'd13;
  localparam logic [4:0] OP_RRC  = 5'd14;
  localparam logic [4:0] OP_SWAP = 5'd15;
  localparam logic [4:0] OP_SETC = 5'd16;
  localparam logic [4:0] OP_CLRC = 5'd17;
  localparam logic [4:0] OP_CPLC = 5'd18;
  localparam logic [4:0] OP_XCHD = 5'd19;

  localparam logic [H-1:0] NIB_MAX = H'(9);

  // adder / subtractor
  logic         cin;
  logic [W:0]   sum9, dif9;
  assign cin  = (op_i == OP_ADD) ? 1'b0 : cy_i;
  assign sum9 = {1'b0, acc_i} + {1'b0, opnd_i} + {{W{1'b0}}, cin};
  assign dif9 = {1'b0, acc_i} - {1'b0, opnd_i} - {{W{1'b0}}, cy_i};

  logic add_c, add_ac, add_ov, sub_c, sub_ac, sub_ov;
  assign add_c  = sum9[W];
  assign add_ac = sum9[H] ^ acc_i[H] ^ opnd_i[H];
  assign add_ov = sum9[W-1] ^ acc_i[W-1] ^ opnd_i[W-1] ^ sum9[W];
  assign sub_c  = dif9[W];
  assign sub_ac = dif9[H] ^ acc_i[H] ^ opnd_i[H];
  assign sub_ov = dif9[W-1] ^ acc_i[W-1] ^ opnd_i[W-1] ^ dif9[W];

  // decimal adjust
  logic         lo_fix, hi_fix, da_c1;
  logic [W:0]   da_s1, da_s2;
  assign lo_fix = (acc_i[H-1:0] > NIB_MAX) || ac_i;
  assign da_s1  = {1'b0, acc_i} + (lo_fix ? (W+1)'(6) : '0);
  assign da_c1  = cy_i | da_s1[W];
  assign hi_fix = (da_s1[W-1:H] > NIB_MAX) || da_c1;
  assign da_s2  = {1'b0, da_s1[W-1:0]} + (hi_fix ? (W+1)'(8'h60) : '0);

  // multiply / divide
  logic [2*W-1:0] prod;
  logic           dz;
  logic [W-1:0]   quo, rem;
  assign prod = (2*W)'(acc_i) * (2*W)'(opnd_i);
  assign dz   = (opnd_i == '0);
  always_comb begin
    if (dz) begin
      quo = '0;
      rem = '0;
    end else begin
      quo = acc_i / opnd_i;
      rem = acc_i % opnd_i;
    end
  end

  // result and flag-effect map
  logic c_n, ov_n, ac_n;
  always_comb begin
    res_o   = acc_i;
    aux_o   = opnd_i;
    c_n     = cy_i;
    ov_n    = ov_i;
    ac_n    = ac_i;
    cy_we_o = 1'b0;
    ov_we_o = 1'b0;
    ac_we_o = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDC: begin
        res_o = sum9[W-1:0];
        c_n = add_c; ov_n = add_ov; ac_n = add_ac;
        cy_we_o = 1'b1; ov_we_o = 1'b1; ac_we_o = 1'b1;
      end
      OP_SUBB: begin
        res_o = dif9[W-1:0];
        c_n = sub_c; ov_n = sub_ov; ac_n = sub_ac;
        cy_we_o = 1'b1; ov_we_o = 1'b1; ac_we_o = 1'b1;
      end
      OP_DA: begin
        res_o = da_s2[W-1:0];
        c_n = da_c1 | da_s2[W];
        cy_we_o = 1'b1;
      end
      OP_MUL: begin
        res_o = prod[W-1:0];
        aux_o = prod[2*W-1:W];
        c_n = 1'b0; ov_n = (prod[2*W-1:W] != '0);
        cy_we_o = 1'b1; ov_we_o = 1'b1;
      end
      OP_DIV: begin
        res_o = quo;
        aux_o = rem;
        c_n = 1'b0; ov_n = dz;
        cy_we_o = 1'b1; ov_we_o = 1'b1;
      end
      OP_AND:  res_o = acc_i & opnd_i;
      OP_OR:   res_o = acc_i | opnd_i;
      OP_XOR:  res_o = acc_i ^ opnd_i;
      OP_CLRA: res_o = '0;
      OP_CPLA: res_o = ~acc_i;
      OP_RL:   res_o = {acc_i[W-2:0], acc_i[W-1]};
      OP_RR:   res_o = {acc_i[0], acc_i[W-1:1]};
      OP_RLC: begin
        res_o = {acc_i[W-2:0], cy_i};
        c_n = acc_i[W-1];
        cy_we_o = 1'b1;
      end
      OP_RRC: begin
        res_o = {cy_i, acc_i[W-1:1]};
        c_n = acc_i[0];
        cy_we_o = 1'b1;
      end
      OP_SWAP: res_o = {acc_i[H-1:0], acc_i[W-1:H]};
      OP_SETC: begin c_n = 1'b1;  cy_we_o = 1'b1; end
      OP_CLRC: begin c_n = 1'b0;  cy_we_o = 1'b1; end
      OP_CPLC: begin c_n = ~cy_i; cy_we_o = 1'b1; end
      OP_XCHD: begin
        res_o = {acc_i[W-1:H], opnd_i[H-1:0]};
        aux_o = {opnd_i[W-1:H], acc_i[H-1:0]};
      end
      default: ;
    endcase
  end

  assign cy_o = c_n;
  assign ov_o = ov_n;
  assign ac_o = ac_n;

  // guards
  always_comb begin
    // R6
    if (op_i >= OP_AND && op_i <= OP_CPLA)
      logic_noflag_chk: assert (!cy_we_o && !ov_we_o && !ac_we_o);
    // R8
    if (op_i == OP_RLC || op_i == OP_RRC || op_i == OP_DA)
      conly_we_chk: assert (cy_we_o && !ov_we_o && !ac_we_o);
    // R4
    if (op_i == OP_MUL)
      mul_cclr_chk: assert (cy_we_o && !cy_o && (ov_o == (aux_o != '0)));
    // R5
    if (op_i == OP_DIV)
      div_zero_chk: assert (!cy_o && (ov_o == (opnd_i == '0)));
    // R3
    if (op_i == OP_DA && cy_i)
      da_keepc_chk: assert (cy_o);
    // R10
    if (op_i == OP_CPLC)
      cplc_inv_chk: assert (cy_o != cy_i && res_o == acc_i);
    // R11
    if (op_i == OP_XCHD)
      xchd_hold_chk: assert (res_o[W-1:H] == acc_i[W-1:H] && aux_o[H-1:0] == acc_i[H-1:0]);
    // R12
    if (op_i <= 5'd31 && !ov_we_o)
      ov_pass_chk: assert (ov_o == ov_i);
    // R12
    if (op_i <= 5'd31 && !ac_we_o)
      ac_pass_chk: assert (ac_o == ac_i);
  end
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] op;
  logic [7:0] acc, opnd, res, aux;
  logic cy, ov, ac, cy_o, ov_o, ac_o, cy_we, ov_we, ac_we;
  int checks = 0;
  int failures = 0;

  acc_alu dut_i (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .cy_i(cy), .ov_i(ov), .ac_i(ac),
    .res_o(res), .aux_o(aux), .cy_o(cy_o), .ov_o(ov_o), .ac_o(ac_o),
    .cy_we_o(cy_we), .ov_we_o(ov_we), .ac_we_o(ac_we)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample after next posedge
  task automatic run(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                     input logic c, input logic v, input logic h);
    @(negedge clk);
    op <= o; acc <= a; opnd <= b; cy <= c; ov <= v; ac <= h;
    @(posedge clk);
    #1;
  endtask

  // fl = {cy_we, ov_we, ac_we, cy, ov, ac}
  task automatic expect_all(string tag, logic [7:0] r, logic [7:0] x, logic [5:0] fl);
    chk({tag, " res"}, res, r);
    chk({tag, " aux"}, aux, x);
    chk({tag, " flags"}, {cy_we, ov_we, ac_we, cy_o, ov_o, ac_o}, fl);
  endtask

  task automatic t_add;
    run(5'd0, 8'h3A, 8'h26, 1'b1, 1'b1, 1'b0); expect_all("R1 add ac", 8'h60, 8'h26, 6'b111_001);
    run(5'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0); expect_all("R1 add ov", 8'h80, 8'h01, 6'b111_011);
    run(5'd1, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0); expect_all("R1 addc wrap", 8'h00, 8'h00, 6'b111_101);
    run(5'd0, 8'h80, 8'h80, 1'b0, 1'b0, 1'b1); expect_all("R1 add neg ov", 8'h00, 8'h80, 6'b111_110);
    for (int a = 0; a < 256; a += 23) begin
      for (int b = 0; b < 256; b += 37) begin
        int s; logic sov;
        run(5'd0, 8'(a), 8'(b), 1'b1, 1'b0, 1'b0);
        s = a + b;
        sov = (a[7] == b[7]) && (s[7] != a[7]);
        chk("R1 sweep res", res, s & 255);
        chk("R1 sweep flags", {cy_o, ov_o, ac_o},
            {s > 255, sov, ((a & 15) + (b & 15)) > 15});
      end
    end
  endtask

  task automatic t_subb;
    run(5'd2, 8'h10, 8'h01, 1'b0, 1'b1, 1'b0); expect_all("R2 subb ac", 8'h0F, 8'h01, 6'b111_001);
    run(5'd2, 8'h00, 8'h01, 1'b1, 1'b1, 1'b0); expect_all("R2 subb borrow", 8'hFE, 8'h01, 6'b111_101);
    run(5'd2, 8'h80, 8'h01, 1'b0, 1'b0, 1'b0); expect_all("R2 subb ov", 8'h7F, 8'h01, 6'b111_011);
    run(5'd2, 8'h55, 8'h55, 1'b1, 1'b1, 1'b0); expect_all("R2 subb cin", 8'hFF, 8'h55, 6'b111_101);
  endtask

  task automatic t_da;
    run(5'd3, 8'h9A, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R3 da both", 8'h00, 8'h00, 6'b100_110);
    run(5'd3, 8'h15, 8'h00, 1'b0, 1'b0, 1'b1); expect_all("R3 da ac", 8'h1B, 8'h00, 6'b100_001);
    run(5'd3, 8'h23, 8'h00, 1'b1, 1'b0, 1'b0); expect_all("R3 da keep c", 8'h83, 8'h00, 6'b100_100);
  endtask

  task automatic t_muldiv;
    run(5'd4, 8'h10, 8'h10, 1'b1, 1'b0, 1'b1); expect_all("R4 mul big", 8'h00, 8'h01, 6'b110_011);
    run(5'd4, 8'h0F, 8'h11, 1'b1, 1'b1, 1'b0); expect_all("R4 mul fit", 8'hFF, 8'h00, 6'b110_000);
    run(5'd5, 8'hFB, 8'h12, 1'b1, 1'b1, 1'b1); expect_all("R5 div", 8'h0D, 8'h11, 6'b110_001);
    run(5'd5, 8'h42, 8'h00, 1'b1, 1'b0, 1'b0); expect_all("R5 div zero", 8'h00, 8'h00, 6'b110_010);
  endtask

  task automatic t_logic;
    run(5'd6,  8'hF0, 8'h3C, 1'b1, 1'b0, 1'b1); expect_all("R6 and",  8'h30, 8'h3C, 6'b000_101);
    run(5'd7,  8'hF0, 8'h3C, 1'b0, 1'b1, 1'b0); expect_all("R6 or",   8'hFC, 8'h3C, 6'b000_010);
    run(5'd8,  8'hF0, 8'h3C, 1'b1, 1'b1, 1'b1); expect_all("R6 xor",  8'hCC, 8'h3C, 6'b000_111);
    run(5'd9,  8'hF0, 8'h3C, 1'b1, 1'b0, 1'b1); expect_all("R6 clra", 8'h00, 8'h3C, 6'b000_101);
    run(5'd10, 8'hF0, 8'h3C, 1'b0, 1'b0, 1'b1); expect_all("R6 cpla", 8'h0F, 8'h3C, 6'b000_001);
  endtask

  task automatic t_rot;
    run(5'd11, 8'h81, 8'h00, 1'b0, 1'b1, 1'b0); expect_all("R7 rl",  8'h03, 8'h00, 6'b000_010);
    run(5'd13, 8'h81, 8'h00, 1'b1, 1'b0, 1'b1); expect_all("R7 rr",  8'hC0, 8'h00, 6'b000_101);
    run(5'd12, 8'h81, 8'h00, 1'b0, 1'b1, 1'b1); expect_all("R8 rlc", 8'h02, 8'h00, 6'b100_111);
    run(5'd14, 8'h81, 8'h00, 1'b0, 1'b0, 1'b0); expect_all("R8 rrc", 8'h40, 8'h00, 6'b100_100);
    run(5'd14, 8'h02, 8'h00, 1'b1, 1'b0, 1'b1); expect_all("R8 rrc cin", 8'h81, 8'h00, 6'b100_001);
    run(5'd15, 8'hA5, 8'h00, 1'b1, 1'b1, 1'b0); expect_all("R9 swap", 8'h5A, 8'h00, 6'b000_110);
  endtask

  task automatic t_carry;
    run(5'd16, 8'h77, 8'h11, 1'b0, 1'b1, 1'b1); expect_all("R10 setc",   8'h77, 8'h11, 6'b100_111);
    run(5'd17, 8'h77, 8'h11, 1'b1, 1'b0, 1'b0); expect_all("R10 clrc",   8'h77, 8'h11, 6'b100_000);
    run(5'd18, 8'h77, 8'h11, 1'b1, 1'b0, 1'b1); expect_all("R10 cplc 1", 8'h77, 8'h11, 6'b100_001);
    run(5'd18, 8'h77, 8'h11, 1'b0, 1'b1, 1'b0); expect_all("R10 cplc 0", 8'h77, 8'h11, 6'b100_110);
  endtask

  task automatic t_xchd_misc;
    run(5'd19, 8'h12, 8'hAB, 1'b1, 1'b0, 1'b1); expect_all("R11 xchd", 8'h1B, 8'hA2, 6'b000_101);
    run(5'd31, 8'h5C, 8'hE1, 1'b0, 1'b1, 1'b1); expect_all("R12 unused", 8'h5C, 8'hE1, 6'b000_011);
    run(5'd20, 8'h01, 8'h02, 1'b1, 1'b0, 1'b0); expect_all("R12 unused low", 8'h01, 8'h02, 6'b000_100);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    op = 5'd0; acc = 8'h00; opnd = 8'h00; cy = 1'b0; ov = 1'b0; ac = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    expect_all("R1 idle add zero", 8'h00, 8'h00, 6'b111_000);
    t_add();
    t_subb();
    t_da();
    t_muldiv();
    t_logic();
    t_rot();
    t_carry();
    t_xchd_misc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule